// File: doc/BRIEF.md
# Masked Byte-Write Video DRAM Random Port

This block models the random-access side of a 16-bit video memory whose control strobes are asynchronous. A fast system clock samples the row strobe, column strobe, output gate, function select, the two byte write enables, the multiplexed address and the input data bus. Two-flop synchronizers bring them into the clock domain, and their edges are found by comparing each sample with the one before it.

A row address is taken when the row strobe falls. A column address is taken each time the column strobe falls, so page-mode accesses work within one row cycle. From the levels of the enables around those edges, the block tells apart a read, an early write, a late write and a per-bit masked write. It then updates a 16 x 16 x 16-bit array, or drives the stored word on the output bus with a registered output enable.

Top module: `vdr_rport`

## Requirements
- R1: After reset `dq_oe` is 0 and no array word is written until a qualified row cycle occurs.
- R2: A row cycle opens only if, at the falling edge of `row_n`, `col_n` is 1, `gate_n` is 1 and `fsel` is 0. Otherwise, column strobes in that row cycle neither write the array nor assert `dq_oe`.
- R3: `addr` is taken as the row at the falling edge of `row_n` and as the column at each falling edge of `col_n`. The array word index is {row, column}.
- R4: While `col_n` is low in an open cycle, with `wlo_n` = 1, `whi_n` = 1 and `gate_n` = 0, `dq_oe` is 1 and `dq_out` shows the addressed word. With `gate_n` = 1, `dq_oe` stays 0.
- R5: If `wlo_n` or `whi_n` is 0 at the falling edge of `col_n`, the cycle is an early write. `dq_in` at that edge is written, `dq_oe` stays 0, and only the enabled lanes change: `wlo_n` covers bits 7:0 and `whi_n` covers bits 15:8.
- R6: If a write enable falls while `col_n` is already low, the cycle is a late write. `dq_in` at that enable edge is written into the lane or lanes whose enable fell.
- R7: If `wlo_n` or `whi_n` is 0 at the falling edge of `row_n`, `dq_in` is loaded into the bit mask. A mask bit of 0 keeps that stored bit and a mask bit of 1 lets it be written.
- R8: The loaded mask applies to every column access of the same row cycle. When `row_n` rises, the mask returns to all ones, so later unmasked cycles write every enabled bit.
- R9: `dq_oe` falls on the third rising clock edge after `col_n` rises: two synchronizer stages, then the output register.
- R10: A falling edge of `col_n` with `fsel` = 1 is ignored. No column is taken and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| gate_n | input | 1 | Output gate, low permits a read to drive |
| fsel | input | 1 | Function select, must be low for normal cycles |
| wlo_n | input | 1 | Write enable for bits 7:0, active low |
| whi_n | input | 1 | Write enable for bits 15:8, active low |
| addr | input | 4 | Multiplexed row/column address |
| dq_in | input | 16 | Write data, or mask data at the row edge |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Output enable for the data bus |

## Verification
The mask loaded at the row edge and the lane selection from the byte enables act on the same write. The bench provokes this with a masked row cycle followed by two page-mode early writes that enable both lanes, using preloaded words whose bits differ inside and outside the mask. It judges the result by reading each word back and comparing it against old-and-not-mask OR new-and-mask. A later unmasked write to the same word shows that the mask was released when the row strobe rose.

// File: rtl/vdr_pkg.sv
package vdr_pkg;
    parameter int DW = 16;
    parameter int AW = 4;
    localparam int LANES = DW / 8;
    localparam int WORDS = 2 ** (2 * AW);

    typedef struct packed {
        logic          row_n;
        logic          col_n;
        logic          gate_n;
        logic          fsel;
        logic          wlo_n;
        logic          whi_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] dq;
    } pins_t;

    typedef struct packed {
        logic          act;
        logic          colv;
        logic          early;
        logic          oe;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [DW-1:0] mask;
        logic          p_row;
        logic          p_col;
        logic          p_wlo;
        logic          p_whi;
    } ctl_t;
endpackage

// File: rtl/vdr_sync.sv
module vdr_sync #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= din[i];
                s2_q <= s1_q;
            end
        end
        assign dout[i] = s2_q;
    end
endmodule

// File: rtl/vdr_mem.sv
module vdr_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              wen,
    input  logic [DW/8-1:0]   wlane,
    input  logic [DW-1:0]     wmask,
    input  logic [2*AW-1:0]   waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [2*AW-1:0]   raddr,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 2 ** (2 * AW);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < DW; b++) begin
            if (wen && wlane[b/8] && wmask[b]) begin
                store[waddr][b] <= wdata[b];
            end
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/vdr_rport.sv
module vdr_rport
    import vdr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_n,
    input  logic          col_n,
    input  logic          gate_n,
    input  logic          fsel,
    input  logic          wlo_n,
    input  logic          whi_n,
    input  logic [3:0]    addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic          dq_oe
);
    localparam int PW = $bits(pins_t);
    localparam pins_t PIN_RST = '{row_n: 1'b1, col_n: 1'b1, gate_n: 1'b1,
                                  fsel: 1'b0, wlo_n: 1'b1, whi_n: 1'b1,
                                  addr: '0, dq: '0};
    localparam ctl_t CTL_RST = '{act: 1'b0, colv: 1'b0, early: 1'b0, oe: 1'b0,
                                 row: '0, col: '0, mask: '1,
                                 p_row: 1'b1, p_col: 1'b1, p_wlo: 1'b1, p_whi: 1'b1};

    pins_t              raw, syn;
    ctl_t               ctl_d, ctl_q;
    logic               wen;
    logic [LANES-1:0]   wlane;
    logic [DW-1:0]      rdata;

    assign raw = '{row_n: row_n, col_n: col_n, gate_n: gate_n, fsel: fsel,
                   wlo_n: wlo_n, whi_n: whi_n, addr: addr, dq: dq_in};

    vdr_sync #(.W(PW), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (syn)
    );

    always_comb begin
        logic row_fall, row_rise, col_fall, col_rise, lo_fall, hi_fall, any_we;
        ctl_d    = ctl_q;
        wen      = 1'b0;
        wlane    = '0;
        row_fall = ctl_q.p_row & ~syn.row_n;
        row_rise = ~ctl_q.p_row & syn.row_n;
        col_fall = ctl_q.p_col & ~syn.col_n;
        col_rise = ~ctl_q.p_col & syn.col_n;
        lo_fall  = ctl_q.p_wlo & ~syn.wlo_n;
        hi_fall  = ctl_q.p_whi & ~syn.whi_n;
        any_we   = ~syn.wlo_n | ~syn.whi_n;

        ctl_d.p_row = syn.row_n;
        ctl_d.p_col = syn.col_n;
        ctl_d.p_wlo = syn.wlo_n;
        ctl_d.p_whi = syn.whi_n;

        if (row_fall) begin
            ctl_d.act   = syn.col_n & syn.gate_n & ~syn.fsel;
            ctl_d.row   = syn.addr;
            ctl_d.mask  = any_we ? syn.dq : '1;
            ctl_d.colv  = 1'b0;
            ctl_d.early = 1'b0;
        end else if (row_rise) begin
            ctl_d.act   = 1'b0;
            ctl_d.mask  = '1;
            ctl_d.colv  = 1'b0;
            ctl_d.early = 1'b0;
        end else if (ctl_q.act) begin
            if (col_fall && !syn.fsel) begin
                ctl_d.col   = syn.addr;
                ctl_d.colv  = 1'b1;
                ctl_d.early = any_we;
                if (any_we) begin
                    wen   = 1'b1;
                    wlane = {~syn.whi_n, ~syn.wlo_n};
                end
            end else if (ctl_q.colv && !syn.col_n && !ctl_q.early
                         && (lo_fall || hi_fall)) begin
                wen   = 1'b1;
                wlane = {hi_fall, lo_fall};
            end
            if (col_rise) begin
                ctl_d.colv  = 1'b0;
                ctl_d.early = 1'b0;
            end
        end

        ctl_d.oe = ctl_d.act & ctl_d.colv & ~syn.col_n & syn.wlo_n & syn.whi_n
                 & ~syn.gate_n & ~ctl_d.early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    vdr_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk  (clk),
        .wen  (wen),
        .wlane(wlane),
        .wmask(ctl_q.mask),
        .waddr({ctl_q.row, ctl_d.col}),
        .wdata(syn.dq),
        .raddr({ctl_d.row, ctl_d.col}),
        .rdata(rdata)
    );

    assign dq_out = rdata;
    assign dq_oe  = ctl_q.oe;
endmodule

// File: rtl/vdr_rport_chk.sv
module vdr_rport_chk
    import vdr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input pins_t            syn,
    input ctl_t             q,
    input logic             wen,
    input logic [LANES-1:0] wlane,
    input logic             dq_oe
);
    p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!syn.col_n && syn.wlo_n && syn.whi_n && !syn.gate_n));

    p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn.col_n) |=> !dq_oe);

    p_write_needs_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wen |-> q.act);

    p_lane_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wen |-> (wlane != '0));

    p_mask_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(syn.row_n) && syn.row_n) |-> (q.mask == '1));
endmodule

bind vdr_rport vdr_rport_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .syn  (syn),
    .q    (ctl_q),
    .wen  (wen),
    .wlane(wlane),
    .dq_oe(dq_oe)
);

// File: tb/vdr_rport_test.sv
module vdr_rport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_n = 1'b1, col_n = 1'b1, gate_n = 1'b1, fsel = 1'b0;
    logic        wlo_n = 1'b1, whi_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    vdr_rport uut (.*);

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic row_open(logic [3:0] r, logic lo, logic hi, logic [15:0] d);
        addr = r; wlo_n = lo; whi_n = hi; dq_in = d; gate_n = 1'b1; fsel = 1'b0;
        tick(1); row_n = 1'b0; tick(4);
        wlo_n = 1'b1; whi_n = 1'b1;
    endtask

    task automatic row_close();
        row_n = 1'b1; gate_n = 1'b1; fsel = 1'b0; tick(4);
    endtask

    task automatic col_early(logic [3:0] c, logic lo, logic hi, logic [15:0] d);
        addr = c; wlo_n = lo; whi_n = hi; dq_in = d;
        tick(1); col_n = 1'b0; tick(4);
        col_n = 1'b1; wlo_n = 1'b1; whi_n = 1'b1; tick(4);
    endtask

    task automatic put(logic [3:0] r, logic [3:0] c, logic [15:0] d);
        row_open(r, 1'b1, 1'b1, '0);
        col_early(c, 1'b0, 1'b0, d);
        row_close();
    endtask

    task automatic get(logic [3:0] r, logic [3:0] c, output logic [15:0] d,
                       output logic oe);
        row_open(r, 1'b1, 1'b1, '0);
        addr = c; gate_n = 1'b0; tick(1); col_n = 1'b0; tick(4);
        d = dq_out; oe = dq_oe;
        col_n = 1'b1; gate_n = 1'b1; tick(4);
        row_close();
    endtask

    task automatic t_reset();
        check("R1 oe after reset", {15'd0, dq_oe}, 16'd0);
    endtask

    task automatic t_read_write();
        logic [15:0] d; logic oe;
        put(4'd3, 4'd5, 16'hA5C3);
        put(4'd12, 4'd10, 16'h1234);
        get(4'd3, 4'd5, d, oe);
        check("R3 R4 word 3/5", d, 16'hA5C3);
        check("R4 oe during read", {15'd0, oe}, 16'd1);
        get(4'd12, 4'd10, d, oe);
        check("R3 word 12/10", d, 16'h1234);
        row_open(4'd3, 1'b1, 1'b1, '0);
        addr = 4'd5; gate_n = 1'b1; tick(1); col_n = 1'b0; tick(4);
        check("R4 gate high keeps oe low", {15'd0, dq_oe}, 16'd0);
        col_n = 1'b1; tick(4); row_close();
    endtask

    task automatic t_byte_early();
        logic [15:0] d; logic oe;
        row_open(4'd3, 1'b1, 1'b1, '0);
        addr = 4'd5; dq_in = 16'hFFFF; wlo_n = 1'b0; gate_n = 1'b0;
        tick(1); col_n = 1'b0; tick(4);
        check("R5 early write keeps oe low", {15'd0, dq_oe}, 16'd0);
        col_n = 1'b1; wlo_n = 1'b1; gate_n = 1'b1; tick(4); row_close();
        get(4'd3, 4'd5, d, oe);
        check("R5 low lane only", d, 16'hA5FF);
    endtask

    task automatic t_late();
        logic [15:0] d; logic oe;
        put(4'd2, 4'd9, 16'h3344);
        row_open(4'd2, 1'b1, 1'b1, '0);
        addr = 4'd9; tick(1); col_n = 1'b0; tick(4);
        dq_in = 16'hABCD; whi_n = 1'b0; tick(4);
        dq_in = 16'h0000; tick(2);
        whi_n = 1'b1; col_n = 1'b1; tick(4); row_close();
        get(4'd2, 4'd9, d, oe);
        check("R6 late write high lane", d, 16'hAB44);
    endtask

    task automatic t_mask();
        logic [15:0] d; logic oe;
        put(4'd5, 4'd1, 16'h0000);
        put(4'd5, 4'd2, 16'hFFFF);
        row_open(4'd5, 1'b0, 1'b1, 16'h0FF0);
        col_early(4'd1, 1'b0, 1'b0, 16'hFFFF);
        col_early(4'd2, 1'b0, 1'b0, 16'h0000);
        row_close();
        get(4'd5, 4'd1, d, oe);
        check("R7 masked write", d, 16'h0FF0);
        get(4'd5, 4'd2, d, oe);
        check("R8 mask kept in page", d, 16'hF00F);
        put(4'd5, 4'd1, 16'h5555);
        get(4'd5, 4'd1, d, oe);
        check("R8 mask released", d, 16'h5555);
    endtask

    task automatic t_unqualified();
        logic [15:0] d; logic oe;
        put(4'd7, 4'd7, 16'h1111);
        addr = 4'd7; gate_n = 1'b0; tick(1); row_n = 1'b0; tick(4);
        addr = 4'd7; tick(1); col_n = 1'b0; tick(4);
        check("R2 no read without cycle", {15'd0, dq_oe}, 16'd0);
        col_n = 1'b1; gate_n = 1'b1; tick(4);
        col_early(4'd7, 1'b0, 1'b0, 16'hDEAD);
        row_close();
        addr = 4'd7; fsel = 1'b1; tick(1); row_n = 1'b0; tick(4); fsel = 1'b0;
        col_early(4'd7, 1'b0, 1'b0, 16'hBEEF);
        row_close();
        get(4'd7, 4'd7, d, oe);
        check("R2 word unchanged", d, 16'h1111);
    endtask

    task automatic t_fsel_col();
        logic [15:0] d; logic oe;
        row_open(4'd7, 1'b1, 1'b1, '0);
        fsel = 1'b1;
        col_early(4'd7, 1'b0, 1'b0, 16'hBEEF);
        fsel = 1'b0;
        row_close();
        get(4'd7, 4'd7, d, oe);
        check("R10 fsel column ignored", d, 16'h1111);
    endtask

    task automatic t_oe_timing();
        row_open(4'd12, 1'b1, 1'b1, '0);
        addr = 4'd10; gate_n = 1'b0; tick(1); col_n = 1'b0; tick(4);
        check("R9 oe before release", {15'd0, dq_oe}, 16'd1);
        col_n = 1'b1; tick(2);
        check("R9 oe after two edges", {15'd0, dq_oe}, 16'd1);
        tick(1);
        check("R9 oe after third edge", {15'd0, dq_oe}, 16'd0);
        gate_n = 1'b1; tick(3); row_close();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_read_write();
        t_byte_early();
        t_late();
        t_mask();
        t_unqualified();
        t_fsel_col();
        t_oe_timing();
        report();
        $finish;
    end
endmodule